// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Aggregator

This block sits beside a CAN protocol engine and turns the engine's single-cycle event pulses into sticky, host-visible flags, merging them into one interrupt request line. Fault-class events (bus lock, overload, overrun, bus-off entry and recovery, error passive, error warning, bus error) land in an error flag register. Protocol error codes (stuff, form, ACK, CRC, both bit-error polarities, ACK delimiter) land in an error code register. Receive-queue and transmit-queue events land as two status flags. The engine's transmit and receive error counters pass straight through to two read-only registers.

The host reaches the block through a plain 3-bit-address, 8-bit-data register port. Writes take effect at the next clock edge; reads are combinational. Every sticky flag is cleared by writing 0 to its bit; a 1 bit in the written byte leaves that flag as it was, so a host can clear exactly the bits it has handled without a read-modify-write race. The error code register can either collect every code seen (accumulate mode) or keep only the most recent one.

Top module: `can_err_irq_agg`

Register map (address: content): 0 error enable, 1 error flags, 2 error codes, 3 interrupt enable, 4 interrupt status, 5 transmit error count, 6 receive error count, 7 reads zero.

## Requirements
- R1: After reset every register at addresses 0 to 4 reads 0x00 and `irq` is low.
- R2: A pulse on bit k of `fault_evt` sets bit k of the error flag register (address 1) at the next clock edge, and the bit stays set after the pulse ends. Bit order from 7 down to 0: bus lock, overload, overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: Writing a byte to address 1, 2 or 4 clears each sticky flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R4: When an event sets a flag in the same cycle that a host write clears it, the flag is set after that edge.
- R5: With bit 7 of the error code register (address 2) at 1, every `code_evt` pulse ORs its bits into bits 6:0, so codes accumulate. Code bits from 6 down to 0: ACK delimiter, dominant bit error, recessive bit error, CRC, ACK, form, stuff. Bit 7 is a plain read/write mode bit.
- R6: With bit 7 of address 2 at 0, a nonzero `code_evt` replaces bits 6:0 with its own value at the next edge.
- R7: Interrupt status bit 5 reads 1 exactly while some error flag bit and the same bit of the error enable register (address 0) are both 1.
- R8: A `rxq_evt` pulse sets interrupt status bit 4 and a `txq_evt` pulse sets bit 3; both are sticky. Status bits 7, 6, 2, 1, 0 read 0.
- R9: `irq` is high exactly when the interrupt status ANDed with the interrupt enable register (address 3) is nonzero.
- R10: Address 5 reads `tx_err_cnt` and address 6 reads `rx_err_cnt`.
- R11: Writes to status bit 5 and to addresses 5 and 6 change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| fault_evt | input | 8 | Fault event pulses from the engine |
| code_evt | input | 7 | Protocol error code pulses |
| rxq_evt | input | 1 | Receive-queue event pulse |
| txq_evt | input | 1 | Transmit-queue event pulse |
| tx_err_cnt | input | 8 | Engine transmit error counter |
| rx_err_cnt | input | 8 | Engine receive error counter |
| irq | output | 1 | Combined interrupt request |

## Verification
The collision that matters is a host clear write landing in the same cycle as an engine event on the same flag. The bench drives a zero write to the error flag register together with a fault pulse on one bit while other bits are pending, then expects the pulsed bit set and the others cleared. The same race is exercised for accumulate mode, where a clear of one code must leave codes not cleared intact.

// File: rtl/cef_pkg.sv
package cef_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int CODE_W = 7;
    localparam int NREG   = 1 << ADDR_W;
    localparam int QEV_W  = 2;

    localparam int CODE_MODE_BIT = 7;
    localparam int ST_ERR_BIT    = 5;
    localparam int ST_RXQ_BIT    = 4;
    localparam int ST_TXQ_BIT    = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_ERR_EN   = 3'd0,
        A_ERR_FLG  = 3'd1,
        A_ERR_CODE = 3'd2,
        A_IRQ_EN   = 3'd3,
        A_IRQ_STAT = 3'd4,
        A_TX_CNT   = 3'd5,
        A_RX_CNT   = 3'd6,
        A_SPARE    = 3'd7
    } cef_addr_e;

    typedef struct packed {
        logic [DATA_W-1:0] err_en;
        logic [DATA_W-1:0] err_flg;
        logic [DATA_W-1:0] err_code;
        logic [DATA_W-1:0] irq_en;
        logic [DATA_W-1:0] irq_stat;
        logic [DATA_W-1:0] tx_cnt;
        logic [DATA_W-1:0] rx_cnt;
    } cef_view_t;

    function automatic logic [DATA_W-1:0] pack_status(input logic err_sum,
                                                      input logic rxq,
                                                      input logic txq);
        logic [DATA_W-1:0] s;
        s = '0;
        s[ST_ERR_BIT] = err_sum;
        s[ST_RXQ_BIT] = rxq;
        s[ST_TXQ_BIT] = txq;
        return s;
    endfunction

endpackage

// File: rtl/cef_flag_bank.sv
module cef_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wmask_i,
    input  logic         replace_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;
    logic [W-1:0] kept;
    logic [W-1:0] nxt;

    always_comb begin
        kept = wr_i ? (q & wmask_i) : q;
        if (replace_i && (|set_i)) nxt = set_i;
        else                       nxt = kept | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign q_o = q;

    // R4: an event in the same cycle as a clearing write still leaves its bit set
    assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R2: no flag rises without an event on that bit in the cycle before
    assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (rst)
        ((q_o & ~$past(q_o) & ~$past(set_i)) == '0));

    // R6: in replace mode the field holds exactly the latest nonzero event
    assert_latest_only_R6: assert property (@(posedge clk) disable iff (rst)
        (replace_i && (set_i != '0)) |=> (q_o == $past(set_i)));
endmodule

// File: rtl/cef_host_if.sv
module cef_host_if
    import cef_pkg::*;
(
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  cef_view_t               view_i,
    output logic [NREG-1:0]         we_o,
    output logic [DATA_W-1:0]       rdata_o
);
    for (genvar k = 0; k < NREG; k++) begin : g_dec
        assign we_o[k] = wr_i && (addr_i == ADDR_W'(k));
    end

    always_comb begin
        unique case (cef_addr_e'(addr_i))
            A_ERR_EN:   rdata_o = view_i.err_en;
            A_ERR_FLG:  rdata_o = view_i.err_flg;
            A_ERR_CODE: rdata_o = view_i.err_code;
            A_IRQ_EN:   rdata_o = view_i.irq_en;
            A_IRQ_STAT: rdata_o = view_i.irq_stat;
            A_TX_CNT:   rdata_o = view_i.tx_cnt;
            A_RX_CNT:   rdata_o = view_i.rx_cnt;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cef_irq_gen.sv
module cef_irq_gen
    import cef_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] err_flg_i,
    input  logic [DATA_W-1:0] err_en_i,
    input  logic [QEV_W-1:0]  qflg_i,
    input  logic [DATA_W-1:0] irq_en_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              irq_o
);
    logic err_sum;

    assign err_sum = |(err_flg_i & err_en_i);
    assign stat_o  = pack_status(err_sum, qflg_i[1], qflg_i[0]);
    assign irq_o   = |(stat_o & irq_en_i);

    // R9: with every interrupt enable at zero the line stays low
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_en_i == '0) |-> !irq_o);

    // R7: no pending flag means no error summary
    assert_err_sum_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (err_flg_i == '0) |-> !stat_o[ST_ERR_BIT]);
endmodule

// File: rtl/can_err_irq_agg.sv
module can_err_irq_agg
    import cef_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        fault_evt,
    input  logic [6:0]        code_evt,
    input  logic              rxq_evt,
    input  logic              txq_evt,
    input  logic [7:0]        tx_err_cnt,
    input  logic [7:0]        rx_err_cnt,
    output logic              irq
);
    logic [NREG-1:0]   we;
    logic [DATA_W-1:0] err_en_q;
    logic [DATA_W-1:0] irq_en_q;
    logic              accum_q;
    logic [DATA_W-1:0] err_flg;
    logic [CODE_W-1:0] code_fld;
    logic [QEV_W-1:0]  qflg;
    logic [DATA_W-1:0] stat;
    cef_view_t         view;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_en_q <= '0;
            irq_en_q <= '0;
            accum_q  <= 1'b0;
        end else begin
            if (we[A_ERR_EN])   err_en_q <= reg_wdata;
            if (we[A_IRQ_EN])   irq_en_q <= reg_wdata;
            if (we[A_ERR_CODE]) accum_q  <= reg_wdata[CODE_MODE_BIT];
        end
    end

    cef_flag_bank #(.W(DATA_W)) u_fault_bank (
        .clk(clk), .rst(rst), .set_i(fault_evt), .wr_i(we[A_ERR_FLG]),
        .wmask_i(reg_wdata), .replace_i(1'b0), .q_o(err_flg)
    );

    cef_flag_bank #(.W(CODE_W)) u_code_bank (
        .clk(clk), .rst(rst), .set_i(code_evt), .wr_i(we[A_ERR_CODE]),
        .wmask_i(reg_wdata[CODE_W-1:0]), .replace_i(!accum_q), .q_o(code_fld)
    );

    cef_flag_bank #(.W(QEV_W)) u_queue_bank (
        .clk(clk), .rst(rst), .set_i({rxq_evt, txq_evt}), .wr_i(we[A_IRQ_STAT]),
        .wmask_i({reg_wdata[ST_RXQ_BIT], reg_wdata[ST_TXQ_BIT]}),
        .replace_i(1'b0), .q_o(qflg)
    );

    cef_irq_gen u_irq (
        .clk(clk), .rst(rst), .err_flg_i(err_flg), .err_en_i(err_en_q),
        .qflg_i(qflg), .irq_en_i(irq_en_q), .stat_o(stat), .irq_o(irq)
    );

    always_comb begin
        view.err_en   = err_en_q;
        view.err_flg  = err_flg;
        view.err_code = {accum_q, code_fld};
        view.irq_en   = irq_en_q;
        view.irq_stat = stat;
        view.tx_cnt   = tx_err_cnt;
        view.rx_cnt   = rx_err_cnt;
    end

    cef_host_if u_host (
        .wr_i(reg_wr), .addr_i(reg_addr), .view_i(view),
        .we_o(we), .rdata_o(reg_rdata)
    );

    // R3: an all-ones write to the flag register with no event keeps it unchanged
    assert_ones_write_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == 3'd1) && (reg_wdata == 8'hFF) && (fault_evt == '0))
        |=> (err_flg == $past(err_flg)));
endmodule

// File: tb/tb_can_err_irq_agg.sv
module tb_can_err_irq_agg;
    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] fault_evt;
    logic [6:0] code_evt;
    logic       rxq_evt, txq_evt;
    logic [7:0] tx_err_cnt, rx_err_cnt;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_err_irq_agg dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_evt(fault_evt),
        .code_evt(code_evt), .rxq_evt(rxq_evt), .txq_evt(txq_evt),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_fault(input logic [7:0] v);
        @(negedge clk); fault_evt = v;
        @(negedge clk); fault_evt = '0;
    endtask

    task automatic pulse_code(input logic [6:0] v);
        @(negedge clk); code_evt = v;
        @(negedge clk); code_evt = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reset value", v, 8'h00);
        end
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_fault_sticky();
        logic [7:0] v;
        pulse_fault(8'h81);
        rd(3'd1, v); check("R2 flags set and held", v, 8'h81);
        repeat (3) @(negedge clk);
        rd(3'd1, v); check("R2 flags still held", v, 8'h81);
    endtask

    task automatic t_w0c();
        logic [7:0] v;
        wr(3'd1, 8'h7F);
        rd(3'd1, v); check("R3 zero clears bit7 only", v, 8'h01);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); check("R3 ones leave flags", v, 8'h01);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R3 zero clears all", v, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        pulse_fault(8'h06);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h00; fault_evt = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0; fault_evt = '0;
        rd(3'd1, v); check("R4 event beats clear", v, 8'h01);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_accum();
        logic [7:0] v;
        wr(3'd2, 8'h80);
        pulse_code(7'h08);
        pulse_code(7'h01);
        rd(3'd2, v); check("R5 codes accumulate", v, 8'h89);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'hF7; code_evt = 7'h40;
        @(negedge clk);
        reg_wr = 1'b0; code_evt = '0;
        rd(3'd2, v); check("R5 clear one code, R4 new code kept", v, 8'hC1);
        wr(3'd2, 8'h00);
        rd(3'd2, v); check("R3 code field cleared", v, 8'h00);
    endtask

    task automatic t_overwrite();
        logic [7:0] v;
        pulse_code(7'h08);
        rd(3'd2, v); check("R6 first code", v, 8'h08);
        pulse_code(7'h21);
        rd(3'd2, v); check("R6 latest code replaces", v, 8'h21);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_err_summary();
        logic [7:0] v;
        wr(3'd0, 8'h00);
        pulse_fault(8'h04);
        rd(3'd4, v); check("R7 disabled factor no summary", v, 8'h00);
        wr(3'd0, 8'h04);
        rd(3'd4, v); check("R7 enabled factor summary", v, 8'h20);
        check("R9 irq low with enables off", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h20);
        check("R9 irq high on enabled status", {7'b0, irq}, 8'h01);
        wr(3'd4, 8'h00);
        rd(3'd4, v); check("R11 status bit5 not writable", v, 8'h20);
        wr(3'd1, 8'h00);
        rd(3'd4, v); check("R7 summary drops with flag", v, 8'h00);
        check("R9 irq drops", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_queue_flags();
        logic [7:0] v;
        @(negedge clk); rxq_evt = 1'b1;
        @(negedge clk); rxq_evt = 1'b0;
        rd(3'd4, v); check("R8 receive-queue flag", v, 8'h10);
        @(negedge clk); txq_evt = 1'b1;
        @(negedge clk); txq_evt = 1'b0;
        rd(3'd4, v); check("R8 both queue flags", v, 8'h18);
        check("R9 irq low without enable", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'hEF);
        rd(3'd4, v); check("R3 status clear rx only", v, 8'h08);
        wr(3'd3, 8'h10);
        check("R9 irq low for masked tx", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h08);
        check("R9 irq for tx flag", {7'b0, irq}, 8'h01);
        wr(3'd4, 8'h00);
        rd(3'd4, v); check("R8 queue flags cleared", v, 8'h00);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_counters();
        logic [7:0] v;
        tx_err_cnt = 8'h7F; rx_err_cnt = 8'h80;
        rd(3'd5, v); check("R10 tx counter", v, 8'h7F);
        rd(3'd6, v); check("R10 rx counter", v, 8'h80);
        wr(3'd5, 8'h11);
        wr(3'd6, 8'h22);
        rd(3'd5, v); check("R11 tx counter unchanged", v, 8'h7F);
        rd(3'd6, v); check("R11 rx counter unchanged", v, 8'h80);
        rd(3'd0, v); check("R11 enable untouched", v, 8'h04);
        rd(3'd7, v); check("R10 spare reads zero", v, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        fault_evt = '0; code_evt = '0; rxq_evt = 1'b0; txq_evt = 1'b0;
        tx_err_cnt = '0; rx_err_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_fault_sticky();
        t_w0c();
        t_collision();
        t_accum();
        t_overwrite();
        t_err_summary();
        t_queue_flags();
        t_counters();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule